// File: doc/BRIEF.md
# Asynchronous Character Framer

The framer turns parallel characters into start/data/parity/stop frames on a serial output and recovers characters from a serial input. It runs from a single clock. A 16x oversampling enable from an external baud generator paces both directions, so one bit cell is sixteen enable pulses long. A six-bit format word sets the character length, the stop-bit count and a three-bit parity code. The transmit and receive sides read different meanings from the parity code, so the two directions can use different parity rules.

The register side loads characters through a one-deep transmit holding stage and watches the empty and complete flags. On the receive side it reads each character together with its parity-error and framing-error flags, and acknowledges it to clear the ready flag. In echo mode every received character is sent back on the transmit line with the parity bit exactly as it arrived. Modem handshake lines and interrupt logic belong to neighbouring blocks.

Top module: `async_char_framer`

## Requirements
- R1: `cfg[1:0]` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of `tx_data` are sent. The unused upper bits of `rx_data` read as zero.
- R2: `cfg[4:2]` is the parity code. A parity bit follows the data unless `cfg[4:3]` is 11. The transmitter makes odd parity when `cfg[2]` is 1 and even parity when `cfg[2]` is 0.
- R3: The receiver checks parity only when `cfg[4]` is 0. It expects odd parity for codes 001 and 010 and even parity for codes 000 and 011. `rx_perr` goes high when the check fails.
- R4: With `cfg[5]`=0 the transmitter sends one stop bit. With `cfg[5]`=1 it sends 1.5 stop bits for 5-bit characters and 2 stop bits otherwise. The receiver always checks only the first stop bit.
- R5: The line idles high. A frame is one low start bit, then the data least significant bit first, then parity, then the stop bits. Each cell lasts 16 `tick16` pulses, and the receiver samples every cell in its middle.
- R6: A low pulse on `rx_line` that is high again at the middle of the start cell is ignored and produces no character.
- R7: `rx_ready` goes high when a character completes and stays high until `rx_ack`. If a completion and `rx_ack` fall in the same cycle, `rx_ready` stays set.
- R8: `rx_ferr` goes high when the first stop bit is sampled low.
- R9: `tx_empty` goes low on an accepted `tx_wr` and goes high again when the shifter takes the character. `tx_done` is high only when both the holding stage and the shifter are idle. It rises once the last stop bit has finished.
- R10: While `echo_en` is 1, each received character and its received parity bit are sent again unchanged, whatever transmit parity the code selects.
- R11: After reset `tx_line`, `tx_empty` and `tx_done` are 1, and `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable, one cycle wide |
| cfg | input | 6 | Format word: [1:0] length, [4:2] parity code, [5] stop select |
| echo_en | input | 1 | Retransmit received characters |
| tx_wr | input | 1 | Load `tx_data` into the holding stage |
| tx_data | input | 8 | Character to send |
| tx_empty | output | 1 | Holding stage empty |
| tx_done | output | 1 | Transmitter fully idle |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_ack | input | 1 | Clears `rx_ready` |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Received character waiting |
| rx_perr | output | 1 | Parity error of last character |
| rx_ferr | output | 1 | Framing error of last character |

## Verification
The completion of a received character can land in the same cycle as an acknowledge from the register side. The bench holds `rx_ack` high for the whole frame and watches `rx_ready`. It passes only if the flag shows at least one high cycle at completion and the new data is visible afterwards. Echo mode also overlaps the two directions. The echoed frame begins at the middle of the incoming stop bit, while the receiver is still in that frame. The bench decodes both directions at once and judges the echoed parity bit against the received bit, not against the generated one.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  // a parity bit is framed unless both upper code bits are set
  function automatic logic par_framed(input logic [2:0] code);
    return !(code[2] && code[1]);
  endfunction

  function automatic logic tx_odd(input logic [2:0] code);
    return code[0];
  endfunction

  function automatic logic rx_check(input logic [2:0] code);
    return !code[2];
  endfunction

  function automatic logic rx_odd(input logic [2:0] code);
    return code[0] ^ code[1];
  endfunction

endpackage

// File: rtl/sf_tx.sv
module sf_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len_sel,
  input  logic              stop_sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_has_par,
  output logic              empty,
  output logic              done,
  output logic              line
);
  localparam int CNT_W = $clog2(OVS);
  localparam int SH_W  = DATA_W + 2;
  localparam int REM_W = $clog2(OVS * (DATA_W + 4) + 1);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hpar_q, hpar_d, hhas_q, hhas_d;
  logic              full_q, full_d, busy_q, busy_d;
  logic [SH_W-1:0]   sh_q, sh_d, frame;
  logic [CNT_W-1:0]  sub_q, sub_d;
  logic [REM_W-1:0]  rem_q, rem_d, total;
  logic              start_ld;
  int                nbits, stop_ticks;

  // frame image and length for the character in the holding stage
  always_comb begin
    nbits = 5 + int'(len_sel);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nbits) frame[i+1] = hold_q[i];
    for (int i = 0; i <= DATA_W; i++)
      if (hhas_q && i == nbits) frame[i+1] = hpar_q;
    if (!stop_sel)          stop_ticks = OVS;
    else if (len_sel == 2'd0) stop_ticks = OVS + OVS / 2;
    else                    stop_ticks = 2 * OVS;
    total = REM_W'(OVS * (1 + nbits + int'(hhas_q)) + stop_ticks);
  end

  always_comb begin
    hold_d   = hold_q;
    hpar_d   = hpar_q;
    hhas_d   = hhas_q;
    full_d   = full_q;
    busy_d   = busy_q;
    sh_d     = sh_q;
    sub_d    = sub_q;
    rem_d    = rem_q;
    start_ld = !busy_q && full_q;
    if (start_ld) begin
      busy_d = 1'b1;
      sh_d   = frame;
      sub_d  = '0;
      rem_d  = total;
      full_d = 1'b0;
    end else if (busy_q && tick) begin
      rem_d = rem_q - REM_W'(1);
      if (sub_q == CNT_W'(OVS - 1)) begin
        sub_d = '0;
        sh_d  = {1'b1, sh_q[SH_W-1:1]};
      end else begin
        sub_d = sub_q + CNT_W'(1);
      end
      if (rem_q == REM_W'(1)) busy_d = 1'b0;
    end
    if (wr && !full_q) begin
      hold_d = wr_data;
      hpar_d = wr_par;
      hhas_d = wr_has_par;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hpar_q <= 1'b0;
      hhas_q <= 1'b0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      rem_q  <= '0;
    end else begin
      hold_q <= hold_d;
      hpar_q <= hpar_d;
      hhas_q <= hhas_d;
      full_q <= full_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      rem_q  <= rem_d;
    end
  end

  assign empty = !full_q;
  assign done  = !busy_q && !full_q;
  assign line  = busy_q ? sh_q[0] : 1'b1;

  // R5: every frame opens with a low start cell
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line);

  // R9: an active frame always has ticks left to run
  p_rem_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> rem_q != '0);

endmodule

// File: rtl/sf_rx.sv
module sf_rx
  import sf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  input  logic [1:0]        len_sel,
  input  logic [2:0]        par_sel,
  input  logic              ack,
  output logic              ready,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              fin,
  output logic [DATA_W-1:0] nxt_data,
  output logic              nxt_par
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int HALF   = OVS / 2;
  localparam int IDX_W  = $clog2(DATA_W + 2);

  rx_state_t         st_q, st_d;
  logic              s1_q, s2_q, prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] buf_q, buf_d, data_q, data_d;
  logic              pbit_q, pbit_d;
  logic              ready_q, ready_d, perr_q, perr_d, ferr_q, ferr_d;
  int                nbits, last;

  always_comb begin
    nbits   = 5 + int'(len_sel);
    last    = nbits + int'(par_framed(par_sel));
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    buf_d   = buf_q;
    pbit_d  = pbit_q;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    fin     = 1'b0;
    case (st_q)
      RX_IDLE: if (prev_q && !s2_q) begin
        st_d   = RX_START;
        cnt_d  = '0;
        buf_d  = '0;
        pbit_d = 1'b0;
      end
      RX_START: if (tick) begin
        if (cnt_q == CNT_W'(HALF - 1)) begin
          st_d  = s2_q ? RX_IDLE : RX_BITS;
          cnt_d = '0;
          idx_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      RX_BITS: if (tick) begin
        if (cnt_q == CNT_W'(OVS - 1)) begin
          cnt_d = '0;
          idx_d = idx_q + IDX_W'(1);
          if (int'(idx_q) == last) begin
            fin    = 1'b1;
            st_d   = RX_IDLE;
            data_d = buf_q;
            perr_d = rx_check(par_sel) && (^buf_q ^ pbit_q ^ rx_odd(par_sel));
            ferr_d = !s2_q;
          end else if (int'(idx_q) < nbits) begin
            for (int i = 0; i < DATA_W; i++)
              if (i == int'(idx_q)) buf_d[i] = s2_q;
          end else begin
            pbit_d = s2_q;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = RX_IDLE;
    endcase
    if (fin)      ready_d = 1'b1;
    else if (ack) ready_d = 1'b0;
    else          ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      buf_q   <= '0;
      pbit_q  <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      s1_q    <= line_in;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      buf_q   <= buf_d;
      pbit_q  <= pbit_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ready_q <= ready_d;
    end
  end

  assign ready    = ready_q;
  assign data     = data_q;
  assign perr     = perr_q;
  assign ferr     = ferr_q;
  assign nxt_data = buf_q;
  assign nxt_par  = pbit_q;

  // R7: a pending character stays flagged until acknowledged
  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !ack |=> ready_q);

  // R5: bit position only advances on an oversampling tick
  p_bits_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BITS) && !tick |=> (st_q == RX_BITS) && $stable(idx_q));

endmodule

// File: rtl/async_char_framer.sv
module async_char_framer
  import sf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [5:0]        cfg,
  input  logic              echo_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_perr,
  output logic              rx_ferr
);
  logic              rs1_q, rs2_q;
  logic              host_par, rx_fin, rx_npar, wr, wpar;
  logic [DATA_W-1:0] rx_ndata, wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  always_comb begin
    host_par = tx_odd(cfg[4:2]);
    for (int i = 0; i < DATA_W; i++)
      if (i < 5 + int'(cfg[1:0])) host_par = host_par ^ tx_data[i];
  end

  // echo path replaces the host path and keeps the received parity bit
  assign wr    = echo_en ? rx_fin   : tx_wr;
  assign wdata = echo_en ? rx_ndata : tx_data;
  assign wpar  = echo_en ? rx_npar  : host_par;

  sf_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk        (clk),
    .rst_n      (rs2_q),
    .tick       (tick16),
    .len_sel    (cfg[1:0]),
    .stop_sel   (cfg[5]),
    .wr         (wr),
    .wr_data    (wdata),
    .wr_par     (wpar),
    .wr_has_par (par_framed(cfg[4:2])),
    .empty      (tx_empty),
    .done       (tx_done),
    .line       (tx_line)
  );

  sf_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk      (clk),
    .rst_n    (rs2_q),
    .tick     (tick16),
    .line_in  (rx_line),
    .len_sel  (cfg[1:0]),
    .par_sel  (cfg[4:2]),
    .ack      (rx_ack),
    .ready    (rx_ready),
    .data     (rx_data),
    .perr     (rx_perr),
    .ferr     (rx_ferr),
    .fin      (rx_fin),
    .nxt_data (rx_ndata),
    .nxt_par  (rx_npar)
  );

  // R10: in echo mode the host write path never reaches the transmitter
  p_echo_source_r10: assert property (@(posedge clk) disable iff (!rs2_q)
    echo_en && !rx_fin |-> !wr);

endmodule

// File: tb/async_char_framer_bench.sv
module async_char_framer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [5:0] cfg = 6'd0;
  logic       echo_en = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_empty, tx_done, tx_line;
  logic       rx_line = 1'b1;
  logic       rx_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_perr, rx_ferr;
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;

  async_char_framer u_async_char_framer (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg(cfg), .echo_en(echo_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .tx_done(tx_done),
    .tx_line(tx_line), .rx_line(rx_line), .rx_ack(rx_ack), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick16 <= (cyc % 4 == 0);

  function automatic logic [7:0] mask(input int n);
    return 8'((1 << n) - 1);
  endfunction
  function automatic logic has_par(input logic [2:0] c);
    return !(c[2] && c[1]);
  endfunction
  function automatic logic exp_txpar(input logic [2:0] c, input logic [7:0] d, input int n);
    return (^(d & mask(n))) ^ c[0];
  endfunction
  function automatic logic exp_perr(input logic [2:0] c, input logic [7:0] d, input logic p);
    return !c[2] && (((^d) ^ p) != (c[0] ^ c[1]));
  endfunction
  function automatic int exp_clk(input logic [5:0] c, input int n);
    int st;
    st = !c[5] ? 16 : (n == 5 ? 24 : 32);
    return 4 * (16 * (1 + n + int'(has_par(c[4:2]))) + st);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    check("R9 empty low after write", tx_empty, 0);
    check("R9 done low after write", tx_done, 0);
  endtask

  task automatic capture_tx(input int n, input logic hp, output logic [7:0] d,
                            output logic p, output logic stop_ok, output int dur);
    int t0;
    @(negedge clk);
    while (tx_line !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (32) @(negedge clk);
    d = 8'd0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      repeat (64) @(negedge clk);
      d[i] = tx_line;
    end
    if (hp) begin
      repeat (64) @(negedge clk);
      p = tx_line;
    end
    repeat (64) @(negedge clk);
    stop_ok = tx_line;
    while (tx_done !== 1'b1) @(negedge clk);
    dur = cyc - t0;
  endtask

  task automatic send_rx(input logic [7:0] d, input int n, input logic hp,
                         input logic p, input logic stopb);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_line = d[i];
      repeat (64) @(negedge clk);
    end
    if (hp) begin
      rx_line = p;
      repeat (64) @(negedge clk);
    end
    rx_line = stopb;
    repeat (64) @(negedge clk);
    rx_line = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic do_tx(input logic [5:0] c, input logic [7:0] d);
    logic [7:0] got;
    logic p, sok;
    int dur, n, ex;
    n = 5 + int'(c[1:0]);
    cfg = c;
    host_write(d);
    capture_tx(n, has_par(c[4:2]), got, p, sok, dur);
    check("R1 R5 tx data bits", got, d & mask(n));
    if (has_par(c[4:2])) check("R2 tx parity bit", p, exp_txpar(c[4:2], d, n));
    check("R5 tx stop high", sok, 1);
    ex = exp_clk(c, n);
    if (dur >= ex - 8 && dur <= ex + 8) check("R4 R9 frame length", ex, ex);
    else check("R4 R9 frame length", dur, ex);
  endtask

  task automatic do_rx(input logic [5:0] c, input logic [7:0] d, input logic p,
                       input logic stopb);
    int n;
    n = 5 + int'(c[1:0]);
    cfg = c;
    send_rx(d, n, has_par(c[4:2]), p, stopb);
    check("R7 rx ready", rx_ready, 1);
    check("R1 rx data", rx_data, d & mask(n));
    check("R3 rx parity error", rx_perr,
          has_par(c[4:2]) ? exp_perr(c[4:2], d & mask(n), p) : 1'b0);
    check("R8 rx framing error", rx_ferr, !stopb);
    @(negedge clk);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    check("R7 ready cleared by ack", rx_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    logic p, sok, seen;
    int dur;
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset line", tx_line, 1);
    check("R11 reset empty", tx_empty, 1);
    check("R11 reset done", tx_done, 1);
    check("R11 reset ready", rx_ready, 0);

    // directed transmit corners
    do_tx({1'b1, 3'b001, 2'b00}, 8'h15);   // 5 bits, odd, 1.5 stop
    do_tx({1'b1, 3'b000, 2'b11}, 8'hA7);   // 8 bits, even, 2 stop
    do_tx({1'b0, 3'b110, 2'b10}, 8'h5A);   // no parity
    do_tx({1'b1, 3'b111, 2'b01}, 8'h3C);   // 6 bits, no parity, 2 stop
    for (int k = 0; k < 10; k++) begin
      d = 8'($urandom);
      do_tx(6'($urandom), d);
    end

    // directed receive corners
    do_rx({1'b0, 3'b010, 2'b11}, 8'h81, 1'b1, 1'b1);  // R3 odd check passes
    do_rx({1'b0, 3'b010, 2'b11}, 8'h81, 1'b0, 1'b1);  // R3 odd check fails
    do_rx({1'b0, 3'b100, 2'b11}, 8'h81, 1'b1, 1'b1);  // R3 check disabled
    do_rx({1'b0, 3'b000, 2'b00}, 8'h1B, 1'b0, 1'b0);  // R8 low stop
    for (int k = 0; k < 10; k++) begin
      d = 8'($urandom);
      do_rx(6'($urandom), d, 1'($urandom), ($urandom % 4) != 0);
    end

    // R6 false start: short low pulse
    @(negedge clk);
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (900) @(negedge clk);
    check("R6 false start ignored", rx_ready, 0);

    // R7 completion and ack in the same cycle
    cfg = {1'b0, 3'b000, 2'b11};
    seen = 1'b0;
    @(negedge clk);
    rx_ack = 1'b1;
    fork
      send_rx(8'hC3, 8, 1'b0, 1'b0, 1'b1);
      begin
        repeat (700) begin
          @(negedge clk);
          if (rx_ready) seen = 1'b1;
        end
      end
    join
    rx_ack = 1'b0;
    check("R7 set wins over ack", seen, 1);
    check("R7 data after collision", rx_data, 8'hC3);

    // R10 echo keeps the received parity bit
    cfg = {1'b0, 3'b010, 2'b11};
    echo_en = 1'b1;
    d = 8'h6D;
    p = ~(^d);                       // differs from generated even parity
    fork
      send_rx(d, 8, 1'b1, p, 1'b1);
      capture_tx(8, 1'b1, got, sok, seen, dur);
    join
    check("R10 echo data", got, d);
    check("R10 echo parity", sok, p);
    echo_en = 1'b0;
    @(negedge clk);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule